// File: doc/BRIEF.md
# Interrupt Redirection Controller with Deferred Unmask

This block routes up to sixteen interrupt input lines to a single delivery output. Every line owns a 64-bit routing entry. The entry holds a vector number, a destination identifier, a delivery-type field, a destination-addressing bit, a trigger-type bit and a mask bit. Software does not address the entries directly. It first writes a register number into a selector register. It then reads or writes the chosen 32-bit half of an entry through a data window, so the whole table fits in two bus offsets.

The block samples each input line and acts only when a line goes from low to high. If the entry is open for delivery, the block issues a one-cycle request that carries the entry's vector and destination. If the entry is masked and marked level-type, the block does not discard the event. It keeps a per-line pending mark. When software later writes the entry so that its mask bit ends up clear, the pending mark is dropped. If the line is still high at that moment, the request is issued then.

When several lines need service in the same cycle, the lowest-numbered line goes first. The rest are held and issued one per cycle in ascending order.

Top module: `irq_route_unit`

## Requirements
- R1: After reset, both 32-bit halves of every entry read 0x00010000, the selector reads 0, and irq_valid is 0.
- R2: A bus write at offset 0x00 loads the selector with the low 8 bits of the data, and a read at 0x00 returns the selector. Reads and writes at offset 0x10 reach the selected register. Reads at any other offset return 0, and writes there change nothing.
- R3: Line n's entry has its low half at selector value 0x10+2n and its high half at 0x11+2n. A window write replaces only the addressed half, and a window read returns only that half.
- R4: At selector values outside 0x10..0x2F, window reads return 0 and window writes change no entry.
- R5: Entry layout: vector in bits [7:0], delivery type in [10:8], addressing bit 11, trigger bit 15 (1 = level), mask bit 16 (1 = masked), destination in [63:56]. Suppose a line is sampled high at a clock edge after being sampled low at the previous edge, and its entry has mask 0, bit 11 = 0 and [10:8] = 000. Then irq_valid is 1 for the cycle after that edge, irq_vector carries bits [7:0] and irq_dest carries bits [63:56]. While irq_valid is 0, irq_vector and irq_dest are 0.
- R6: A line that stays high after its rising edge, or that falls, produces no further delivery.
- R7: A rising line whose entry has mask 1 and trigger bit 1 produces no delivery and sets that line's pending mark.
- R8: A window write that leaves a pending line's mask bit at 0 clears the mark. If the line is high in that write's cycle, the delivery of R5 (using the entry as written) follows that write's edge. If the line is low, nothing is delivered. A later unmasking write delivers nothing.
- R9: A rising line whose entry has mask 1 and trigger bit 0 is dropped: a later unmasking write delivers nothing, even with the line still high.
- R10: A rising line whose entry is unmasked but has bit 11 = 1 or a nonzero [10:8] produces no delivery.
- R11: Lines that need delivery in the same cycle are issued one per cycle, lowest line number first. The others are held until their turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | N_PINS | Interrupt input lines, sampled every cycle |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus offset (0x00 selector, 0x10 data window) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from bus_addr |
| irq_valid | output | 1 | One-cycle delivery strobe |
| irq_vector | output | 8 | Vector of the delivered entry |
| irq_dest | output | 8 | Destination of the delivered entry |

## Verification
The bench targets three cases where a small mistake loses or duplicates an interrupt.

- A masked level-type line that is unmasked while still high must deliver exactly once. A design that forgets the pending mark loses this interrupt, and one that never clears the mark delivers again on the next unmasking write.
- A masked edge-type line, and an unmasked line that is low at the time, must give no delivery on unmask. A design that records every masked edge, or that ignores the line level, would fire a spurious request.
- Three lines rising together must come out one per cycle in ascending order with the right payloads. Without request holding, two of them would be dropped. With a priority error, the vectors would appear out of order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef logic [63:0] redir_t;

   localparam int VEC_LSB  = 0;
   localparam int VEC_W    = 8;
   localparam int DLV_LSB  = 8;
   localparam int DLV_W    = 3;
   localparam int ADRM_BIT = 11;
   localparam int TRIG_BIT = 15;
   localparam int MASK_BIT = 16;
   localparam int DEST_LSB = 56;
   localparam int DEST_W   = 8;

   localparam redir_t ENTRY_RST = 64'h0001_0000_0001_0000;

   // entry may be delivered as fixed type to a physical target
   function automatic logic ent_open(input redir_t e);
      return !e[MASK_BIT] && !e[ADRM_BIT] && (e[DLV_LSB +: DLV_W] == '0);
   endfunction

   function automatic logic ent_masked_level(input redir_t e);
      return e[MASK_BIT] && e[TRIG_BIT];
   endfunction

endpackage

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
   import irq_route_pkg::*;
#(
   parameter int N_PINS     = 16,
   parameter int IDX_W      = 8,
   parameter int ADDR_W     = 5,
   parameter int SEL_OFS    = 0,
   parameter int WIN_OFS    = 16,
   parameter int ENTRY_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [IDX_W-1:0]  sel_idx,
   output redir_t            ent_nxt [N_PINS],
   output logic [N_PINS-1:0] ent_wr
);

   localparam int LIMIT  = ENTRY_BASE + 2 * N_PINS;
   localparam int ENT_IW = (N_PINS > 1) ? $clog2(N_PINS) : 1;

   logic [IDX_W-1:0]  sel_q;
   redir_t            ent_q [N_PINS];
   logic              sel_hit, win_hit, in_range, hi_half;
   logic [IDX_W-1:0]  rel;
   logic [ENT_IW-1:0] ent_no;
   logic [31:0]       win_rd [N_PINS];

   assign sel_idx  = sel_q;
   assign sel_hit  = (bus_addr == ADDR_W'(SEL_OFS));
   assign win_hit  = (bus_addr == ADDR_W'(WIN_OFS));
   assign in_range = (int'(sel_q) >= ENTRY_BASE) && (int'(sel_q) < LIMIT);
   assign rel      = sel_q - IDX_W'(ENTRY_BASE);
   assign hi_half  = rel[0];
   assign ent_no   = rel[ENT_IW:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (bus_wr && sel_hit)
         sel_q <= bus_wdata[IDX_W-1:0];
   end

   for (genvar i = 0; i < N_PINS; i++) begin : g_ent
      assign ent_wr[i] = bus_wr && win_hit && in_range && (ent_no == ENT_IW'(i));

      always_comb begin
         ent_nxt[i] = ent_q[i];
         if (ent_wr[i]) begin
            if (hi_half) ent_nxt[i][63:32] = bus_wdata;
            else         ent_nxt[i][31:0]  = bus_wdata;
         end
      end

      assign win_rd[i] = (in_range && ent_no == ENT_IW'(i))
                         ? (hi_half ? ent_q[i][63:32] : ent_q[i][31:0]) : 32'h0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent_q[i] <= ENTRY_RST;
         else        ent_q[i] <= ent_nxt[i];
      end
   end

   always_comb begin
      bus_rdata = 32'h0;
      if (sel_hit)
         bus_rdata = 32'(sel_q);
      else if (win_hit)
         for (int i = 0; i < N_PINS; i++) bus_rdata = bus_rdata | win_rd[i];
   end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic open_ok,
   input  logic hold_ok,
   input  logic unmasked,
   input  logic ent_wr,
   input  logic grant,
   output logic want,
   output logic pend_q,
   output logic pin_q,
   output logic req_q
);

   logic rise, unmask_hit, fire, pend_d;

   always_comb begin
      rise       = pin && !pin_q;
      unmask_hit = ent_wr && unmasked && pend_q;
      fire       = open_ok && (rise || (unmask_hit && pin));
      want       = req_q || fire;
      pend_d     = pend_q;
      if (unmask_hit)
         pend_d = 1'b0;
      else if (rise && hold_ok)
         pend_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         pend_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         pin_q  <= pin;
         pend_q <= pend_d;
         req_q  <= want && !grant;
      end
   end

endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
   parameter int N = 16
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   if (N == 1) begin : g_single
      assign grant = req;
   end else begin : g_scan
      always_comb begin
         grant = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
   import irq_route_pkg::*;
#(
   parameter int N_PINS     = 16,
   parameter int IDX_W      = 8,
   parameter int ADDR_W     = 5,
   parameter int SEL_OFS    = 0,
   parameter int WIN_OFS    = 16,
   parameter int ENTRY_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_valid,
   output logic [7:0]        irq_vector,
   output logic [7:0]        irq_dest
);

   localparam int ENT_IW = (N_PINS > 1) ? $clog2(N_PINS) : 1;

   if (N_PINS < 1 || N_PINS > 64) begin : g_bad_pins
      $error("irq_route_unit: N_PINS out of range");
   end
   if (IDX_W < ENT_IW + 1 || IDX_W > 31) begin : g_bad_idx
      $error("irq_route_unit: IDX_W cannot cover the table");
   end
   if (ENTRY_BASE % 2 != 0 || ENTRY_BASE + 2 * N_PINS > (1 << IDX_W)) begin : g_bad_base
      $error("irq_route_unit: ENTRY_BASE misplaced");
   end
   if (SEL_OFS == WIN_OFS || WIN_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("irq_route_unit: bus offsets clash");
   end

   redir_t            ent_nxt [N_PINS];
   logic [N_PINS-1:0] ent_wr, want, pend, pin_q, req_q, grant;
   logic [IDX_W-1:0]  sel_idx;
   redir_t            pay;

   irq_reg_bank #(
      .N_PINS(N_PINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
      .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS), .ENTRY_BASE(ENTRY_BASE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_idx(sel_idx),
      .ent_nxt(ent_nxt), .ent_wr(ent_wr)
   );

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      irq_pin_ctrl u_pin (
         .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
         .open_ok(ent_open(ent_nxt[i])),
         .hold_ok(ent_masked_level(ent_nxt[i])),
         .unmasked(!ent_nxt[i][MASK_BIT]),
         .ent_wr(ent_wr[i]), .grant(grant[i]),
         .want(want[i]), .pend_q(pend[i]), .pin_q(pin_q[i]), .req_q(req_q[i])
      );
   end

   irq_pick_low #(.N(N_PINS)) u_pick (.req(want), .grant(grant));

   always_comb begin
      pay = '0;
      for (int i = 0; i < N_PINS; i++)
         if (grant[i]) pay = ent_nxt[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         irq_dest   <= '0;
      end else begin
         irq_valid  <= |grant;
         irq_vector <= pay[VEC_LSB +: VEC_W];
         irq_dest   <= pay[DEST_LSB +: DEST_W];
      end
   end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
   parameter int N_PINS     = 16,
   parameter int IDX_W      = 8,
   parameter int ADDR_W     = 5,
   parameter int WIN_OFS    = 16,
   parameter int ENTRY_BASE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_PINS-1:0] pin_in,
   input logic [N_PINS-1:0] pin_q,
   input logic [N_PINS-1:0] pend,
   input logic [N_PINS-1:0] req_q,
   input logic [N_PINS-1:0] grant,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [IDX_W-1:0]  sel_idx,
   input logic              irq_valid
);

   localparam int LIMIT = ENTRY_BASE + 2 * N_PINS;

   AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R11

   AST_HELD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_q) |=> irq_valid); // R11

   AST_PEND_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend & ~$past(pend) & ~$past(pin_in & ~pin_q)))); // R7

   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> $past((|(pin_in & ~pin_q)) || bus_wr || (|req_q))); // R5

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(WIN_OFS) && !(int'(sel_idx) >= ENTRY_BASE && int'(sel_idx) < LIMIT))
      |-> bus_rdata == 32'h0); // R4

endmodule

bind irq_route_unit irq_route_chk #(
   .N_PINS(N_PINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
   .WIN_OFS(WIN_OFS), .ENTRY_BASE(ENTRY_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_q(pin_q), .pend(pend),
   .req_q(req_q), .grant(grant), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .sel_idx(sel_idx), .irq_valid(irq_valid)
);

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_in = '0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_valid;
   logic [7:0]  irq_vector, irq_dest;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_route_unit uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_dest(irq_dest)
   );

   typedef struct packed {
      logic [3:0]  pin;
      logic [31:0] lo;
      logic [31:0] hi;
      logic        hit;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{4'd0,  32'h0000_0021, 32'h0300_0000, 1'b1},   // R5 edge type
      '{4'd15, 32'h0000_80FE, 32'hA500_0000, 1'b1},   // R5 level type
      '{4'd7,  32'h0000_0140, 32'h0100_0000, 1'b0},   // R10 type 001
      '{4'd4,  32'h0000_0850, 32'h0200_0000, 1'b0},   // R10 bit 11 set
      '{4'd2,  32'h0001_0033, 32'h0400_0000, 1'b0},   // R9 masked edge
      '{4'd9,  32'h0000_0099, 32'hFF00_0000, 1'b1},   // R5
      '{4'd12, 32'h0000_0777, 32'h0600_0000, 1'b0},   // R10 type 111
      '{4'd1,  32'h0000_0010, 32'h0012_3400, 1'b1}    // R5 dest 00
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_out(input string req, input logic v, input logic [7:0] vec, input logic [7:0] dst);
      check(req, {47'd0, irq_valid, irq_vector, irq_dest}, {47'd0, v, v ? vec : 8'h0, v ? dst : 8'h0});
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = '0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = '0;
   endtask

   task automatic set_entry(input int pin, input logic [31:0] lo, input logic [31:0] hi);
      bus_write(5'h00, 32'(8'h11 + 2 * pin));
      bus_write(5'h10, hi);
      bus_write(5'h00, 32'(8'h10 + 2 * pin));
      bus_write(5'h10, lo);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check_out("R1 valid after reset", 1'b0, 8'h0, 8'h0);
      bus_read(5'h00, rd);  check("R1 selector reset", 64'(rd), 64'h0);
      bus_write(5'h00, 32'h10); bus_read(5'h10, rd); check("R1 entry0 low", 64'(rd), 64'h0001_0000);
      bus_write(5'h00, 32'h11); bus_read(5'h10, rd); check("R1 entry0 high", 64'(rd), 64'h0001_0000);
      bus_write(5'h00, 32'h2F); bus_read(5'h10, rd); check("R1 entry15 high", 64'(rd), 64'h0001_0000);

      // selector and stray offsets
      bus_read(5'h00, rd); check("R2 selector readback", 64'(rd), 64'h2F);
      bus_write(5'h04, 32'h55); bus_read(5'h00, rd); check("R2 stray write", 64'(rd), 64'h2F);
      bus_read(5'h04, rd); check("R2 stray read", 64'(rd), 64'h0);

      // half writes
      bus_write(5'h00, 32'h17); bus_write(5'h10, 32'hDEAD_BEEF);
      bus_read(5'h10, rd); check("R3 high half written", 64'(rd), 64'hDEAD_BEEF);
      bus_write(5'h00, 32'h16); bus_read(5'h10, rd); check("R3 low half kept", 64'(rd), 64'h0001_0000);

      // unimplemented indices
      bus_write(5'h00, 32'h30); bus_write(5'h10, 32'hFFFF_FFFF);
      bus_read(5'h10, rd); check("R4 index 0x30 reads zero", 64'(rd), 64'h0);
      bus_write(5'h00, 32'h0F); bus_write(5'h10, 32'hFFFF_FFFF);
      bus_read(5'h10, rd); check("R4 index 0x0F reads zero", 64'(rd), 64'h0);
      bus_write(5'h00, 32'h10); bus_read(5'h10, rd); check("R4 entry0 untouched", 64'(rd), 64'h0001_0000);
      bus_write(5'h00, 32'h2F); bus_read(5'h10, rd); check("R4 entry15 untouched", 64'(rd), 64'h0001_0000);

      // vector table
      for (int k = 0; k < 8; k++) begin
         set_entry(int'(TBL[k].pin), TBL[k].lo, TBL[k].hi);
         pin_in[TBL[k].pin] = 1'b1;
         @(negedge clk);
         check_out($sformatf("R5/R10 row %0d", k), TBL[k].hit, TBL[k].lo[7:0], TBL[k].hi[31:24]);
         @(negedge clk);
         check_out($sformatf("R6 held row %0d", k), 1'b0, 8'h0, 8'h0);
         pin_in[TBL[k].pin] = 1'b0;
         @(negedge clk);
         check_out($sformatf("R6 fall row %0d", k), 1'b0, 8'h0, 8'h0);
      end

      // masked level, unmask while high
      set_entry(6, 32'h0001_8066, 32'h4200_0000);
      pin_in[6] = 1'b1;
      @(negedge clk);
      check_out("R7 masked level held", 1'b0, 8'h0, 8'h0);
      bus_write(5'h00, 32'h1C);
      check_out("R7 no delivery on selector write", 1'b0, 8'h0, 8'h0);
      bus_write(5'h10, 32'h0000_8066);
      check_out("R8 deferred delivery", 1'b1, 8'h66, 8'h42);
      @(negedge clk);
      check_out("R8 single pulse", 1'b0, 8'h0, 8'h0);
      bus_write(5'h10, 32'h0000_8066);
      check_out("R8 no repeat after clear", 1'b0, 8'h0, 8'h0);
      pin_in[6] = 1'b0;
      @(negedge clk);

      // masked level, line dropped before unmask
      set_entry(8, 32'h0001_8088, 32'h1100_0000);
      pin_in[8] = 1'b1;
      @(negedge clk);
      pin_in[8] = 1'b0;
      @(negedge clk);
      check_out("R7 pending no delivery", 1'b0, 8'h0, 8'h0);
      bus_write(5'h10, 32'h0000_8088);
      check_out("R8 unmask with line low", 1'b0, 8'h0, 8'h0);

      // masked edge then unmask while high
      set_entry(2, 32'h0001_0033, 32'h0400_0000);
      pin_in[2] = 1'b1;
      @(negedge clk);
      bus_write(5'h10, 32'h0000_0033);
      check_out("R9 masked edge dropped", 1'b0, 8'h0, 8'h0);
      pin_in[2] = 1'b0;
      @(negedge clk);

      // simultaneous rises
      set_entry(3, 32'h0000_0031, 32'h0300_0000);
      set_entry(5, 32'h0000_0051, 32'h0500_0000);
      set_entry(10, 32'h0000_00A1, 32'h0A00_0000);
      pin_in = 16'h0428;
      @(negedge clk);
      check_out("R11 first lowest", 1'b1, 8'h31, 8'h03);
      @(negedge clk);
      check_out("R11 second", 1'b1, 8'h51, 8'h05);
      @(negedge clk);
      check_out("R11 third", 1'b1, 8'h A1, 8'h0A);
      @(negedge clk);
      check_out("R11 drained", 1'b0, 8'h0, 8'h0);
      pin_in = '0;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule